// File: doc/BRIEF.md
# Matrix Keypad Column Scanner

This block scans a sixteen-key matrix keypad wired as four columns and four rows. It pulls one column low at a time and reads the four row lines, which are pulled high and go low when a closed key joins them to the active column. The row lines are asynchronous to the block, so they first pass through a two-flop synchronizer. Columns step at a slow scan rate, about 100 to 200 Hz. That rate comes from an internal clock-enable divider running off a system clock of about 20 MHz.

When a key is found, the scanner stops on that key's column. It then reports a 4-bit hex code for the key and raises a pressed flag. While the key stays down, the column does not move, the code does not change, and other keys are ignored. Scanning resumes only after the held column's rows have all read high for a whole scan interval. A downstream stage can use the pressed flag and code to register one key per press.

Top module: `keypad_scanner`

## Requirements
- R1: The column output `col_n` is active-low, and exactly one of its four bits is 0 in every cycle. Bit c low means column c is being driven.
- R2: After synchronous reset, `col_n` is 4'b1110 (column 0 active), `key_code` is 0 and `key_pressed` is 0.
- R3: With no key down, the active column advances once every CLK_HZ/SCAN_HZ clock cycles, in the order 0, 1, 2, 3, 0.
- R4: A key at row r and column c closes when `row_n[r]` reads 0 while `col_n[c]` is 0. Once it is detected, `key_pressed` is 1 and `key_code` follows this layout: row 0 = 1,2,3,A; row 1 = 4,5,6,B; row 2 = 7,8,9,C; row 3 = E,0,F,D, with column 0 leftmost.
- R5: While a detected key stays down, `col_n` stays on that key's column and `key_code` stays constant.
- R6: While a key is held, pressing a further key does not change `key_code`.
- R7: If several rows of the active column read low at the same scan step, the lowest-numbered row is reported.
- R8: `key_pressed` falls at the first scan step that ends a full step interval in which all rows of the held column read 1. A shorter release does not end the hold. `key_code` keeps its last value after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, about 20 MHz |
| rst_n | input | 1 | Synchronous reset, active low |
| row_n | input | 4 | Keypad row lines, active low, asynchronous |
| col_n | output | 4 | Keypad column drive, active low, one-hot zero |
| key_code | output | 4 | Hex code of the detected or last detected key |
| key_pressed | output | 1 | High while a detected key is held |

## Verification
The hardest case to reach from the ports is a release that is too short to end the hold. The row lines must go high across a scan step and then fall again before the following step, all while the column is frozen. The bench models the keypad as a set of closed switches that are resolved against the live column drive. This lets it open and close a key for a chosen number of cycles, relative to the measured step period, while watching the pressed flag in every cycle. Overlapping presses, in the same column and in different columns, are built the same way from that switch set.

// File: rtl/keypad_pkg.sv
// Package: shared constants, scan state type and the key layout function.
// Assumes a fixed four-row by four-column matrix.
package keypad_pkg;

    localparam int KP_ROWS  = 4;
    localparam int KP_COLS  = 4;
    localparam int KP_IDX_W = 2;

    typedef enum logic {
        ST_SCAN = 1'b0,
        ST_HOLD = 1'b1
    } scan_state_e;

    // Map a (row, column) position to its hex key code.
    function automatic logic [3:0] kp_code(input logic [KP_IDX_W-1:0] row,
                                           input logic [KP_IDX_W-1:0] col);
        logic [3:0] code;
        case ({row, col})
            4'b00_00: code = 4'h1;
            4'b00_01: code = 4'h2;
            4'b00_10: code = 4'h3;
            4'b00_11: code = 4'hA;
            4'b01_00: code = 4'h4;
            4'b01_01: code = 4'h5;
            4'b01_10: code = 4'h6;
            4'b01_11: code = 4'hB;
            4'b10_00: code = 4'h7;
            4'b10_01: code = 4'h8;
            4'b10_10: code = 4'h9;
            4'b10_11: code = 4'hC;
            4'b11_00: code = 4'hE;
            4'b11_01: code = 4'h0;
            4'b11_10: code = 4'hF;
            default:  code = 4'hD;
        endcase
        return code;
    endfunction

endpackage

// File: rtl/kp_tick_gen.sv
// Module: clock-enable generator. It emits a one-cycle pulse on `tick`
// every DIV clock cycles. Assumes DIV >= 1; DIV == 1 ties the tick high.
module kp_tick_gen #(
    parameter int DIV = 133333
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);

    generate
        if (DIV < 2) begin : g_always
            assign tick = 1'b1;
        end else begin : g_count
            localparam int CW = $clog2(DIV);
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);
            logic [CW-1:0] cnt_q;

            // Count from 0 up to DIV-1, then wrap to 0.
            always_ff @(posedge clk) begin
                if (!rst_n)           cnt_q <= '0;
                else if (cnt_q == LAST) cnt_q <= '0;
                else                  cnt_q <= cnt_q + 1'b1;
            end

            assign tick = (cnt_q == LAST);

            // R3: the enable is a single-cycle pulse, never two in a row.
            assert_tick_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/kp_row_sync.sv
// Module: two-stage synchronizer for the asynchronous row lines.
// Both stages reset to all ones, which means no key is closed.
module kp_row_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);

    logic [W-1:0] meta_q;

    // Pass the row lines through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '1;
            q_sync <= '1;
        end else begin
            meta_q <= d_async;
            q_sync <= meta_q;
        end
    end

endmodule

// File: rtl/kp_scan_core.sv
// Module: scan state machine. It steps the column index on each tick,
// freezes on a detected key, latches its code and releases only after a
// clean full tick interval. Assumes rows_n is already synchronized.
module kp_scan_core
    import keypad_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic [KP_ROWS-1:0]  rows_n,
    output logic [KP_IDX_W-1:0] col_idx,
    output logic [3:0]          key_code,
    output logic                key_down
);

    scan_state_e         state_q;
    logic [KP_IDX_W-1:0] col_q;
    logic [3:0]          code_q;
    logic                low_seen_q;
    logic                hit_any;
    logic [KP_IDX_W-1:0] hit_row;

    // Find the lowest-numbered row that reads low on the active column.
    always_comb begin
        hit_any = ~&rows_n;
        hit_row = '0;
        for (int r = KP_ROWS - 1; r >= 0; r--) begin
            if (!rows_n[r]) hit_row = KP_IDX_W'(r);
        end
    end

    // Note whether any row went low since the last tick.
    always_ff @(posedge clk) begin
        if (!rst_n)       low_seen_q <= 1'b0;
        else if (tick)    low_seen_q <= 1'b0;
        else if (hit_any) low_seen_q <= 1'b1;
    end

    // Scan, hold and release decisions, taken on tick only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SCAN;
            col_q   <= '0;
            code_q  <= '0;
        end else if (tick) begin
            case (state_q)
                ST_SCAN: begin
                    if (hit_any) begin
                        state_q <= ST_HOLD;
                        code_q  <= kp_code(hit_row, col_q);
                    end else begin
                        col_q <= col_q + 1'b1;
                    end
                end
                default: begin
                    if (!hit_any && !low_seen_q) begin
                        state_q <= ST_SCAN;
                        col_q   <= col_q + 1'b1;
                    end
                end
            endcase
        end
    end

    assign col_idx  = col_q;
    assign key_code = code_q;
    assign key_down = (state_q == ST_HOLD);

    // R3: the column moves only on a tick.
    assert_col_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(col_q));

    // R5: a held key keeps its column and code between ticks.
    assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (key_down && !tick) |=> ($stable(col_q) && $stable(code_q)));

    // R6: while held, a row reading low on a tick never changes the code.
    assert_ignore_second_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (key_down && tick && hit_any) |=> ($stable(code_q) && key_down));

    // R4: a low row seen on a scan tick starts a hold.
    assert_detect_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!key_down && tick && hit_any) |=> key_down);

    // R8: a release needs clean rows on the tick.
    assert_release_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (key_down && !tick) |=> key_down);

endmodule

// File: rtl/keypad_scanner.sv
// Module: top of the keypad scanner. It ties together the tick divider,
// the row synchronizer and the scan core, and decodes the column index
// into the active-low column drive. Assumes SCAN_HZ <= CLK_HZ.
module keypad_scanner
    import keypad_pkg::*;
#(
    parameter int CLK_HZ  = 20_000_000,
    parameter int SCAN_HZ = 150
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] row_n,
    output logic [3:0] col_n,
    output logic [3:0] key_code,
    output logic       key_pressed
);

    localparam int TICK_DIV = CLK_HZ / SCAN_HZ;

    logic                tick;
    logic [KP_ROWS-1:0]  rows_s;
    logic [KP_IDX_W-1:0] col_idx;

    kp_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    kp_row_sync #(.W(KP_ROWS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_async(row_n),
        .q_sync (rows_s)
    );

    kp_scan_core u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .rows_n  (rows_s),
        .col_idx (col_idx),
        .key_code(key_code),
        .key_down(key_pressed)
    );

    // Drive low only the column selected by the index.
    generate
        for (genvar c = 0; c < KP_COLS; c++) begin : g_col
            assign col_n[c] = (col_idx != KP_IDX_W'(c));
        end
    endgenerate

    // R1: exactly one column is driven low.
    assert_col_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~col_n) == 1);

endmodule

// File: tb/keypad_scanner_bench.sv
module keypad_scanner_bench;

    localparam int CLK_PERIOD = 10;
    localparam int B_CLK_HZ   = 1000;
    localparam int B_SCAN_HZ  = 100;
    localparam int DIV        = B_CLK_HZ / B_SCAN_HZ;

    // Each entry is {row[1:0], col[1:0], code[3:0]}.
    localparam logic [7:0] VEC [16] = '{
        8'h01, 8'h12, 8'h23, 8'h3A,
        8'h44, 8'h55, 8'h66, 8'h7B,
        8'h87, 8'h98, 8'hA9, 8'hBC,
        8'hCE, 8'hD0, 8'hEF, 8'hFD
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  row_n;
    logic [3:0]  col_n;
    logic [3:0]  key_code;
    logic        key_pressed;
    logic [15:0] closed = '0;   // bit row*4+col = switch closed
    int          total = 0;
    int          bad = 0;
    int          onehot_err = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    keypad_scanner #(.CLK_HZ(B_CLK_HZ), .SCAN_HZ(B_SCAN_HZ)) u_keypad_scanner (
        .clk        (clk),
        .rst_n      (rst_n),
        .row_n      (row_n),
        .col_n      (col_n),
        .key_code   (key_code),
        .key_pressed(key_pressed)
    );

    // Keypad model: a row is pulled low by any closed switch on a driven column.
    always_comb begin
        for (int r = 0; r < 4; r++) begin
            row_n[r] = 1'b1;
            for (int c = 0; c < 4; c++) begin
                if (closed[r*4+c] && !col_n[c]) row_n[r] = 1'b0;
            end
        end
    end

    // R1 monitor: count cycles where the column drive is not one-hot zero.
    always @(negedge clk) begin
        if (rst_n && ($countones(~col_n) != 1)) onehot_err++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=1 expected=0");
        finish_run();
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: reset state.
        chk(col_n == 4'b1110, "R2 col", col_n, 4'b1110);
        chk(key_code == 4'h0, "R2 code", key_code, 0);
        chk(key_pressed == 1'b0, "R2 pressed", key_pressed, 0);

        // R3: step period and order with no key down.
        begin
            logic [3:0] prev;
            int n;
            prev = col_n;
            while (col_n == prev) @(negedge clk);
            for (int s = 0; s < 4; s++) begin
                logic [3:0] expn;
                prev = col_n;
                n = 0;
                while (col_n == prev && n < 4*DIV) begin
                    @(negedge clk);
                    n++;
                end
                chk(n == DIV, "R3 period", n, DIV);
                expn = {prev[2:0], prev[3]};
                chk(col_n == expn, "R3 order", col_n, expn);
            end
        end

        // R4 table walk: each key detected, held on its column, released.
        for (int i = 0; i < 16; i++) begin
            int r, c;
            logic [3:0] exp_code, exp_col;
            r = int'(VEC[i][7:6]);
            c = int'(VEC[i][5:4]);
            exp_code = VEC[i][3:0];
            exp_col = ~(4'b0001 << c);
            closed = 16'h0001 << (r*4+c);
            cyc(6*DIV);
            chk(key_pressed == 1'b1, "R4 pressed", key_pressed, 1);
            chk(key_code == exp_code, "R4 code", key_code, exp_code);
            chk(col_n == exp_col, "R5 held column", col_n, exp_col);
            closed = '0;
            cyc(4*DIV);
            chk(key_pressed == 1'b0, "R8 release", key_pressed, 0);
            chk(key_code == exp_code, "R8 code kept", key_code, exp_code);
        end

        // R5: code and column steady over a long hold of key 9 (row 2, col 2).
        closed = 16'h0001 << (2*4+2);
        cyc(6*DIV);
        begin
            int moves = 0;
            for (int k = 0; k < 5*DIV; k++) begin
                @(negedge clk);
                if (col_n != 4'b1011 || key_code != 4'h9 || !key_pressed) moves++;
            end
            chk(moves == 0, "R5 stable hold", moves, 0);
        end
        closed = '0;
        cyc(4*DIV);

        // R6: hold key 1 (row 0, col 0), add key 6 (row 1, col 2): code stays 1.
        closed = 16'h0001;
        cyc(6*DIV);
        closed = closed | (16'h0001 << (1*4+2));
        cyc(6*DIV);
        chk(key_code == 4'h1, "R6 second key ignored", key_code, 4'h1);
        chk(col_n == 4'b1110, "R6 column frozen", col_n, 4'b1110);
        // R8: releasing the first key lets the scan find the second.
        closed = 16'h0001 << (1*4+2);
        cyc(8*DIV);
        chk(key_code == 4'h6, "R8 rescan after release", key_code, 4'h6);
        chk(key_pressed == 1'b1, "R8 second key pressed", key_pressed, 1);
        closed = '0;
        cyc(4*DIV);

        // R7: B (row 1, col 3) and D (row 3, col 3) together: lowest row wins.
        closed = (16'h0001 << (1*4+3)) | (16'h0001 << (3*4+3));
        cyc(6*DIV);
        chk(key_code == 4'hB, "R7 lowest row", key_code, 4'hB);
        closed = '0;
        cyc(4*DIV);

        // R8: a release shorter than one step interval keeps the hold.
        closed = 16'h0001 << (1*4+1);
        cyc(6*DIV);
        begin
            int drops = 0;
            closed = '0;
            for (int k = 0; k < DIV/2; k++) begin
                @(negedge clk);
                if (!key_pressed) drops++;
            end
            closed = 16'h0001 << (1*4+1);
            for (int k = 0; k < 3*DIV; k++) begin
                @(negedge clk);
                if (!key_pressed) drops++;
            end
            chk(drops == 0, "R8 short release ignored", drops, 0);
            chk(key_code == 4'h5, "R8 code after glitch", key_code, 4'h5);
        end
        closed = '0;
        cyc(4*DIV);

        // R1: one column low in every sampled cycle.
        chk(onehot_err == 0, "R1 one column low", onehot_err, 0);

        // R2: reset in the middle of a hold returns to the reset state.
        closed = 16'h0001 << (3*4+2);
        cyc(6*DIV);
        rst_n = 1'b0;
        closed = '0;
        cyc(2);
        rst_n = 1'b1;
        @(negedge clk);
        chk(col_n == 4'b1110, "R2 col after reset", col_n, 4'b1110);
        chk(key_code == 4'h0, "R2 code after reset", key_code, 0);
        chk(key_pressed == 1'b0, "R2 pressed after reset", key_pressed, 0);

        finish_run();
    end

endmodule